// File: doc/BRIEF.md
# Program Request Write Guard

This block sits behind the serial front end of a small non-volatile byte array. It decides whether a decoded program request may start. For array writes it also checks the target address. It then models the self-timed erase-and-program period that follows a start. The block holds the write-enable latch and three configuration bits. Two of those bits fence off a read-only region at the top of the array. The third is a stored enable flag that software can set.

Several inhibit sources combine here:
- the latch, which is clear after reset,
- the disable command,
- the level of the protect pin,
- the read-only region,
- a low-supply flag.

The pin always refuses configuration writes. It refuses data writes only when the array holds 512 bytes or fewer. Once a write starts, the block reports busy for a fixed number of cycles. While busy it ignores every command, but the status byte can still be read at all times.

Top module: `write_guard`

## Requirements
- R1: After reset, `statusOut` is 8'h00, and `grantArray`, `grantStatus` and `busy` are low.
- R2: `cmdWren` sets the latch, shown in `statusOut` bit 1, one cycle later. `cmdWrdi` clears it one cycle later.
- R3: An array request is granted only when all of the following hold: the latch is set, `lowSupply` is low, the address lies outside the read-only region, and the pin rule of R5 is met. A grant is a one-cycle pulse on `grantArray` in the cycle after the request.
- R4: While `wpPinN` is low, a status request is refused.
- R5: While `wpPinN` is low and `ADDR_W` <= 9, an array request is refused. For larger arrays the pin has no effect on array requests.
- R6: The region select is held in `statusOut` bits 3:2. The encodings are:
  - 00: no region.
  - 01: addresses whose two top bits are 11.
  - 10: addresses whose top bit is 1.
  - 11: every address.
- R7: While `lowSupply` is high, no request of either kind is granted.
- R8: A refused request clears the latch one cycle later.
- R9: After a grant, `busy` and `statusOut` bit 0 are high for exactly `WRITE_CYCLES` cycles, starting in the cycle of the grant pulse. The latch clears in the same cycle that `busy` falls.
- R10: While `busy` is high, all commands and requests are ignored, and `statusOut` stays readable.
- R11: A granted status request loads `statusIn` bit 7 into `statusOut` bit 7, and `statusIn` bits 3:2 into `statusOut` bits 3:2. It does this in the cycle of the grant pulse. All other bits of `statusIn` are ignored, and `statusOut` bits 6:4 always read 0.
- R12: When several inputs are asserted in one idle cycle, only the highest-ranked one acts. The ranking, highest first, is: `cmdWrdi`, then `cmdWren`, then `reqStatus`, then `reqArray`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowSupply | input | 1 | Low-supply indication, which inhibits every write |
| wpPinN | input | 1 | Write-protect pin level, with low meaning protect |
| cmdWren | input | 1 | Decoded write-enable command pulse |
| cmdWrdi | input | 1 | Decoded write-disable command pulse |
| reqStatus | input | 1 | Status write request pulse |
| statusIn | input | 8 | New status byte that goes with `reqStatus` |
| reqArray | input | 1 | Array write request pulse |
| reqAddr | input | ADDR_W | Byte address of the array request |
| grantArray | output | 1 | One-cycle grant for an array write |
| grantStatus | output | 1 | One-cycle grant for a status write |
| busy | output | 1 | A self-timed write cycle is running |
| statusOut | output | 8 | Status byte: {enable flag, 000, region[1:0], latch, busy} |

## Verification
The interesting collisions are between commands and a request in the same cycle, and between the last busy cycle and a new request. For the first, the bench raises enable, disable and both request kinds together. It expects only the top-ranked input to act. For the second, it keeps firing requests and commands while a write cycle runs down. It expects them all to be ignored, up to and including the cycle in which busy falls and the latch clears. A reference model in the bench judges both cases cycle by cycle, under directed sequences and under random traffic.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startArr;
    logic startSts;
  } wg_strobe_t;
endpackage

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowSupply,
  input  logic              wpPinN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              reqStatus,
  input  logic              reqArray,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              busy,
  input  logic              wel,
  input  logic [1:0]        bp,
  output wg_strobe_t        strobes
);
  localparam bit PIN_GUARDS_DATA = (ADDR_W <= 9);

  logic inRegion;
  logic pinBlocksData;
  logic arrOk;
  logic stsOk;

  always_comb begin
    unique case (bp)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = (reqAddr[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   inRegion = reqAddr[ADDR_W-1];
      default: inRegion = 1'b1;
    endcase
  end

  generate
    if (PIN_GUARDS_DATA) begin : g_pinData
      assign pinBlocksData = ~wpPinN;
    end else begin : g_noPinData
      assign pinBlocksData = 1'b0;
    end
  endgenerate

  assign arrOk = wel & ~lowSupply & ~inRegion & ~pinBlocksData;
  assign stsOk = wel & ~lowSupply & wpPinN;

  always_comb begin
    strobes = '0;
    if (!busy) begin
      if (cmdWrdi)        strobes.clrWel = 1'b1;
      else if (cmdWren)   strobes.setWel = 1'b1;
      else if (reqStatus) begin
        if (stsOk) strobes.startSts = 1'b1;
        else       strobes.clrWel   = 1'b1;
      end else if (reqArray) begin
        if (arrOk) strobes.startArr = 1'b1;
        else       strobes.clrWel   = 1'b1;
      end
    end
  end

  AST_LOWV_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |-> !(strobes.startArr || strobes.startSts)); // R7
  AST_PIN_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    !wpPinN |-> !strobes.startSts); // R4
endmodule

// File: rtl/wg_dpath.sv
module wg_dpath
  import wg_pkg::*;
#(
  parameter int WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  wg_strobe_t strobes,
  input  logic [7:0] statusIn,
  output logic       wel,
  output logic [1:0] bp,
  output logic       wpen,
  output logic       busyR,
  output logic       grantArray,
  output logic       grantStatus
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel         <= 1'b0;
      bp          <= 2'b00;
      wpen        <= 1'b0;
      busyR       <= 1'b0;
      cnt         <= '0;
      grantArray  <= 1'b0;
      grantStatus <= 1'b0;
    end else begin
      grantArray  <= strobes.startArr;
      grantStatus <= strobes.startSts;
      if (busyR) begin
        if (cnt == '0) begin
          busyR <= 1'b0;
          wel   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (strobes.clrWel) wel <= 1'b0;
        if (strobes.setWel) wel <= 1'b1;
        if (strobes.startArr || strobes.startSts) begin
          busyR <= 1'b1;
          cnt   <= CNT_MAX;
        end
        if (strobes.startSts) begin
          wpen <= statusIn[7];
          bp   <= statusIn[3:2];
        end
      end
    end
  end

  AST_WEL_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyR) |-> !wel); // R9
  AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busyR) && busyR) |-> ($stable(bp) && $stable(wpen) && !grantArray && !grantStatus)); // R10
  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (grantArray || grantStatus) |-> $past(wel)); // R3
  AST_GRANT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (grantArray || grantStatus) |-> busyR); // R9
endmodule

// File: rtl/write_guard.sv
module write_guard
  import wg_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowSupply,
  input  logic              wpPinN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              reqStatus,
  input  logic [7:0]        statusIn,
  input  logic              reqArray,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              grantArray,
  output logic              grantStatus,
  output logic              busy,
  output logic [7:0]        statusOut
);
  wg_strobe_t strobes;
  logic       wel;
  logic       wpen;
  logic [1:0] bp;

  wg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lowSupply(lowSupply), .wpPinN(wpPinN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .reqStatus(reqStatus),
    .reqArray(reqArray), .reqAddr(reqAddr), .busy(busy), .wel(wel),
    .bp(bp), .strobes(strobes)
  );

  wg_dpath #(.WRITE_CYCLES(WRITE_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusIn(statusIn),
    .wel(wel), .bp(bp), .wpen(wpen), .busyR(busy),
    .grantArray(grantArray), .grantStatus(grantStatus)
  );

  assign statusOut = {wpen, 3'b000, bp, wel, busy};
endmodule

// File: tb/write_guard_bench.sv
module write_guard_bench;
  localparam int AW = 9;
  localparam int WC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lowSupply = 1'b0;
  logic          wpPinN = 1'b1;
  logic          cmdWren = 1'b0;
  logic          cmdWrdi = 1'b0;
  logic          reqStatus = 1'b0;
  logic [7:0]    statusIn = 8'h00;
  logic          reqArray = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          grantArray, grantStatus, busy;
  logic [7:0]    statusOut;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  bit       mWel = 0, mWpen = 0, mBusy = 0;
  bit [1:0] mBp = 0;
  int       mCnt = 0;
  bit       eGa, eGs;

  always #10 clk = ~clk;

  write_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_write_guard (
    .clk(clk), .rstN(rstN), .lowSupply(lowSupply), .wpPinN(wpPinN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .reqStatus(reqStatus),
    .statusIn(statusIn), .reqArray(reqArray), .reqAddr(reqAddr),
    .grantArray(grantArray), .grantStatus(grantStatus), .busy(busy),
    .statusOut(statusOut)
  );

  function automatic bit inRegion(input bit [1:0] b, input bit [AW-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a[AW-1] & a[AW-2];
      2'b10:   return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] expStatus();
    return {mWpen, 3'b000, mBp, mWel, mBusy};
  endfunction

  task automatic modelStep();
    eGa = 0; eGs = 0;
    if (mBusy) begin
      if (mCnt == 0) begin mBusy = 0; mWel = 0; end
      else mCnt--;
    end else if (cmdWrdi) mWel = 0;
    else if (cmdWren) mWel = 1;
    else if (reqStatus) begin
      if (mWel && !lowSupply && wpPinN) begin
        eGs = 1; mBusy = 1; mCnt = WC - 1;
        mWpen = statusIn[7]; mBp = statusIn[3:2];
      end else mWel = 0;
    end else if (reqArray) begin
      if (mWel && !lowSupply && wpPinN && !inRegion(mBp, reqAddr)) begin
        eGa = 1; mBusy = 1; mCnt = WC - 1;
      end else mWel = 0;
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (grantArray !== eGa || grantStatus !== eGs || busy !== mBusy ||
        statusOut !== expStatus()) begin
      fails++;
      $display("FAIL %s: ga=%b gs=%b busy=%b st=%h expected ga=%b gs=%b busy=%b st=%h",
               tag, grantArray, grantStatus, busy, statusOut,
               eGa, eGs, mBusy, expStatus());
    end
  endtask

  task automatic step(input string tag, input bit wren, input bit wrdi,
                      input bit rs, input bit [7:0] sIn, input bit ra,
                      input bit [AW-1:0] addr, input bit low, input bit pin);
    cmdWren = wren; cmdWrdi = wrdi; reqStatus = rs; statusIn = sIn;
    reqArray = ra; reqAddr = addr; lowSupply = low; wpPinN = pin;
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 8'h00, 0, '0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    eGa = 0; eGs = 0;
    compare("R1 reset state");
    rstN = 1'b1;
    step("R3 request before enable refused", 0, 0, 0, 8'h00, 1, 9'h000, 0, 1);
    step("R2 enable sets latch", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R12 disable outranks enable", 1, 1, 0, 8'h00, 0, '0, 0, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R5 pin low refuses data write", 0, 0, 0, 8'h00, 1, 9'h010, 0, 0);
    step("R8 refusal cleared latch", 0, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R7 low supply refuses status write", 0, 0, 1, 8'h8C, 0, '0, 1, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R4 pin low refuses status write", 0, 0, 1, 8'h8C, 0, '0, 0, 0);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R11 status write all ones", 0, 0, 1, 8'hFF, 0, '0, 0, 1);
    for (int i = 0; i < WC; i++)
      step("R10 commands ignored while busy R9", i[0], ~i[0], 1, 8'h00, 1, 9'h000, 0, 1);
    step("R9 latch cleared after cycle", 0, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R6 whole array protected", 0, 0, 0, 8'h00, 1, 9'h000, 0, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R11 select upper quarter", 0, 0, 1, 8'h74, 0, '0, 0, 1);
    idle("R9 wait", WC);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R6 upper quarter refused", 0, 0, 0, 8'h00, 1, 9'h1FF, 0, 1);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R12 enable outranks array request", 1, 0, 0, 8'h00, 1, 9'h17F, 0, 1);
    step("R6 below quarter granted R3", 0, 0, 0, 8'h00, 1, 9'h17F, 0, 1);
    idle("R9 wait", WC);
    step("R2 enable", 1, 0, 0, 8'h00, 0, '0, 0, 1);
    step("R12 status outranks array", 0, 0, 1, 8'h00, 1, 9'h000, 0, 1);
    idle("R9 wait", WC);
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] sIn;
      sIn = 8'($urandom);
      step("random R3 R6 R10 R12",
           ($urandom % 100) < 35, ($urandom % 100) < 5,
           ($urandom % 100) < 10, sIn,
           ($urandom % 100) < 35, AW'($urandom),
           ($urandom % 100) < 8, ($urandom % 100) < 85);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule